// File: doc/BRIEF.md
# Registered Static Memory with Write Pass-Through

A single-clock synchronous static memory with separate input and output data buses. Every request input is captured into a register on the rising clock edge: the address, the input word, the chip enable, the write enable and the output enable. In the following cycle the captured request is carried out. A read loads the addressed word into an output register. A write loads the captured input word into that same output register, so the written data appears on the outputs. The output register therefore shows new data two rising edges after the request was presented, for reads and writes alike.

The chip enable does not deselect the memory. Its only effect is to decide whether a write cycle stores its word in the array. When it is inactive, the write cycle still passes its data through to the outputs. Only the registered output enable controls whether the outputs are driven. The tri-state is modelled as a data word plus a valid flag. The default depth is kept small for elaboration; `ADDR_W = 17` gives the full 131,072 words of 9 bits.

The captured request is classified into a cycle state: `CYC_IDLE` (after reset, until the first edge out of reset), `CYC_READ` (write enable sampled high), `CYC_WRITE` (write and chip enable both sampled low) and `CYC_PASS` (write enable low, chip enable high). Every state is reached from every state on each edge, according to the sampled controls. Reset returns the machine to `CYC_IDLE`.

Top module: `sreg_sram`

## Requirements
- R1: While reset is asserted, and until the first request reaches the outputs, `dout_vld` is 0 and `dout` is 0.
- R2: A read (we_n low = 0 means write, so we_n = 1) presented before rising edge k puts the word stored at that address on `dout` after edge k+1.
- R3: A write with ce_n = 0 and we_n = 0 stores the word in the array, and a later read of that address returns it.
- R4: A write cycle (we_n = 0) puts its input word on `dout` after edge k+1, whatever the value of ce_n.
- R5: A write cycle with ce_n = 1 leaves the array unchanged: a later read of the address returns the previous contents.
- R6: A read with ce_n = 1 behaves exactly like a read with ce_n = 0; chip enable never deselects the memory.
- R7: `dout_vld` after edge k+1 equals the inverse of oe_n presented before edge k, for every cycle type. Neither ce_n nor we_n affects it.
- R8: A read of an address written in the immediately preceding cycle returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low reset of the registers (not the array) |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Input data word |
| ce_n | input | 1 | Chip enable, active low; gates array writes only |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | DATA_W | Output register contents |
| dout_vld | output | 1 | 1 when outputs are driven, 0 for high impedance |

## Verification
The hardest situation to bring about is a read that lands right after a write to the same address while chip enable flips between the two. Only the cycle order then separates a stored write from a pass-only one. Random stimulus confines addresses to a sixteen-word window so that back-to-back collisions are frequent. All three controls are drawn independently each cycle. Directed sequences force the pass-only write followed by a read of the untouched word, and the write-then-read pair.

// File: rtl/sreg_sram_pkg.sv
package sreg_sram_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_PASS  = 2'd3
    } cyc_e;

endpackage

// File: rtl/sreg_in_stage.sv
module sreg_in_stage
    import sreg_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q,
    output logic              oe_q,
    output cyc_e              state
);

    cyc_e state_nxt;

    // Classify the request being sampled on this edge.
    always_comb begin
        unique case ({we_n, ce_n})
            2'b00:   state_nxt = CYC_WRITE;
            2'b01:   state_nxt = CYC_PASS;
            default: state_nxt = CYC_READ;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CYC_IDLE;
        else        state <= state_nxt;
    end

    // Data-path capture registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            din_q  <= '0;
            oe_q   <= 1'b1;
        end else begin
            addr_q <= addr;
            din_q  <= din;
            oe_q   <= oe_n;
        end
    end

    // R6: chip enable alone never turns a request away from a read.
    a_r6_ce_ignored_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        we_n |=> (state == CYC_READ));

endmodule

// File: rtl/sreg_array.sv
module sreg_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

    // R3: a strobed write lands at its address on the next edge.
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

    // R5: without the strobe the addressed word keeps its value.
    a_r5_array_held: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (mem[$past(wr_addr)] == $past(mem[wr_addr])));

endmodule

// File: rtl/sreg_out_stage.sv
module sreg_out_stage
    import sreg_sram_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_e              state,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] din_q,
    input  logic              oe_q,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);

    logic [DATA_W-1:0] dout_nxt;

    // Output select per cycle state.
    always_comb begin
        unique case (state)
            CYC_IDLE:  dout_nxt = dout;
            CYC_READ:  dout_nxt = rd_data;
            CYC_WRITE: dout_nxt = din_q;
            CYC_PASS:  dout_nxt = din_q;
            default:   dout_nxt = dout;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout     <= dout_nxt;
            dout_vld <= ~oe_q;
        end
    end

    // R1: nothing is driven while the machine is idle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_IDLE) |-> !dout_vld);

    // R2: a read loads the array word.
    a_r2_read_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_READ) |=> (dout == $past(rd_data)));

    // R4: any write cycle passes its input word through.
    a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_WRITE || state == CYC_PASS) |=> (dout == $past(din_q)));

    // R7: drive state follows the captured output enable only.
    a_r7_vld_follows_oe: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dout_vld == !$past(oe_q)));

endmodule

// File: rtl/sreg_sram.sv
module sreg_sram
    import sreg_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic              oe_q;
    cyc_e              state;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;

    sreg_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .din    (din),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .addr_q (addr_q),
        .din_q  (din_q),
        .oe_q   (oe_q),
        .state  (state)
    );

    assign wr_en = (state == CYC_WRITE);

    sreg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (addr_q),
        .wr_data (din_q),
        .rd_addr (addr_q),
        .rd_data (rd_data)
    );

    sreg_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .rd_data  (rd_data),
        .din_q    (din_q),
        .oe_q     (oe_q),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

endmodule

// File: tb/sreg_sram_tb.sv
module sreg_sram_tb;

    localparam int AW = 10;
    localparam int DW = 9;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [DW-1:0] dout;
    logic          dout_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [DW-1:0] model [DEPTH];

    // Two-slot pipeline of expectations: slot 1 newest, slot 2 due now.
    bit            p1_v = 1'b0, p2_v = 1'b0;
    logic [DW-1:0] p1_d, p2_d;
    logic          p1_o, p2_o;
    string         p1_t, p2_t;

    always #5 clk = ~clk;

    sreg_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .dout(dout), .dout_vld(dout_vld)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
        end
    endtask

    // Expected output word for one request, from the requirements.
    function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a, input logic [DW-1:0] d,
                                               input logic w);
        return (w == 1'b0) ? d : model[a];
    endfunction

    task automatic do_op(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic c,
                         input logic w, input logic o, input string tag);
        @(negedge clk);
        if (p2_v) begin
            check(p2_t, dout, p2_d);
            check("R7", {{(DW-1){1'b0}}, dout_vld}, {{(DW-1){1'b0}}, ~p2_o});
        end
        p2_v = p1_v; p2_d = p1_d; p2_o = p1_o; p2_t = p1_t;
        addr = a; din = d; ce_n = c; we_n = w; oe_n = o;
        p1_v = 1'b1;
        p1_d = exp_word(a, d, w);
        p1_o = o;
        p1_t = tag;
        if (!w && !c) model[a] = d;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic c, input string tag);
        do_op(a, '0, c, 1'b1, 1'b0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [AW-1:0] ra;
        logic [DW-1:0] rdat;
        logic rc, rw, ro;
        logic [AW-1:0] last_a;
        logic last_wr;
        string tg;
        void'($urandom(32'd20240611));

        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", dout, '0);
        check("R1", {{(DW-1){1'b0}}, dout_vld}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {{(DW-1){1'b0}}, dout_vld}, '0);

        // Fill the array (R3 writes) so later reads have known data.
        for (int i = 0; i < DEPTH; i++)
            do_op(i[AW-1:0], DW'((i * 37 + 5) & ((1 << DW) - 1)), 1'b0, 1'b0, 1'b0, "R4");

        // Directed: stored write then read (R3).
        do_op(10'd100, 9'h1A5, 1'b0, 1'b0, 1'b0, "R4");
        rd(10'd7, 1'b0, "R2");
        rd(10'd100, 1'b0, "R3");
        // Pass-only write: output shows data, array unchanged (R4, R5).
        do_op(10'd200, 9'h0F0, 1'b1, 1'b0, 1'b0, "R4");
        rd(10'd3, 1'b0, "R2");
        rd(10'd200, 1'b0, "R5");
        // Read with chip enable inactive (R6).
        rd(10'd100, 1'b1, "R6");
        // Write then immediately read same address (R8).
        do_op(10'd300, 9'h155, 1'b0, 1'b0, 1'b0, "R4");
        rd(10'd300, 1'b0, "R8");
        // Outputs off on a write and a read, on with ce high (R7).
        do_op(10'd301, 9'h0AA, 1'b0, 1'b0, 1'b1, "R4");
        do_op(10'd301, 9'h000, 1'b1, 1'b1, 1'b1, "R2");
        do_op(10'd301, 9'h000, 1'b1, 1'b1, 1'b0, "R6");
        // Largest address and all-ones data.
        do_op(10'h3FF, 9'h1FF, 1'b0, 1'b0, 1'b0, "R4");
        rd(10'h3FF, 1'b0, "R8");

        // Random phase in a 16-word window.
        last_a = '0; last_wr = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            ra   = AW'($urandom_range(0, 15));
            rdat = DW'($urandom);
            rc   = 1'($urandom);
            rw   = 1'($urandom);
            ro   = ($urandom_range(0, 3) == 0);
            if (!rw)                          tg = "R4";
            else if (last_wr && ra == last_a) tg = "R8";
            else if (rc)                      tg = "R6";
            else                              tg = "R2";
            do_op(ra, rdat, rc, rw, ro, tg);
            last_a = ra; last_wr = !rw && !rc;
        end

        // Drain the pipeline.
        rd('0, 1'b0, "R2");
        rd('0, 1'b0, "R2");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule